// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block takes characters off a single asynchronous serial line. It runs from a tick enable that the surrounding logic asserts sixteen times per nominal bit period. When idle, it watches the synchronised line for a high-to-low transition. It then checks that the low level is still present at the middle of the start bit, and reads every later bit by a two-out-of-three vote. The three samples are taken at oversample ticks 7, 8 and 9 of each bit, counted from the detected edge.

Bit timing is aligned afresh on each start edge and kept for that one character only. Because of this, transmitter and receiver may run from independent clocks whose rates differ slightly. The character format is set on four configuration inputs and latched at each start edge: data length, parity on/off, parity sense, and one or two stop bits. A finished character is presented right-justified with a single-cycle valid pulse and two error flags.

Top module: `ovs_async_rx`

## Requirements
- R1: The line idles high and passes through a two-flop synchroniser. A high-to-low change between two successive enabled ticks starts a character, and that tick counts as oversample tick 0.
- R2: The start bit is confirmed by the vote at ticks 7, 8 and 9. If the vote reads 1, the start is discarded with no output and the receiver returns to idle.
- R3: Every bit is the majority of its samples at ticks 7, 8 and 9 of its 16-tick period. A disturbance on any single one of those ticks does not change the received value.
- R4: Bit timing advances only on cycles where `tick_en` is high. It is re-aligned at each start edge, so 5-bit frames whose bit period is 15 or 17 ticks, sent back to back, are received correctly.
- R5: `cfg_len` selects 0=5, 1=6, 2=7, 3=8 data bits, received LSB first. `rx_data` is right-justified with every bit above the length at 0.
- R6: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 selects even parity (data plus parity bit hold an even number of ones) and 1 selects odd. A mismatch sets `rx_par_err`; with parity off, `rx_par_err` is 0.
- R7: `cfg_two_stop` selects 1 (0) or 2 (1) stop bits. If any stop bit votes 0, `rx_frm_err` is set and the character is still delivered. After that, no new start is accepted until the line has been seen high.
- R8: `rx_valid` is a one-cycle pulse, once per accepted character, issued after the last stop bit has been decided. `rx_data` and the flags hold their values until the next pulse.
- R9: After reset, `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversample tick, 16 per nominal bit |
| rxd_in | input | 1 | Serial line, idles high |
| cfg_len | input | 2 | Data length code, 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rx_data | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_par_err | output | 1 | Parity mismatch on this character |
| rx_frm_err | output | 1 | A stop bit read as 0 |

## Verification
The bench uses the defaults: 16 ticks per bit, an 8-bit data path and two synchroniser stages. At this size every combination of length, parity mode and stop count can be swept with several data words each, and the 5-bit odd-parity format is covered with all 32 codes. Because the bench drives the line tick by tick, it can place single-tick disturbances on individual vote samples, shorten or stretch bit periods to 15 or 17 ticks, and build start glitches that end just before the vote window. The frame builder in the bench also corrupts parity and individual stop bits, and spaces the ticks out to exercise the enable gating.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT
  } rx_state_e;

  // two-out-of-three vote
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic din,
  output logic line,
  output logic fall_tick
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], din};
  end

  assign line = sync_q[STAGES-1];

  // line value seen at the previous enabled tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b1;
    else if (tick_en) prev_q <= line;
  end

  assign fall_tick = tick_en & prev_q & ~line;

endmodule

// File: rtl/ovs_rx_bitclk.sv
module ovs_rx_bitclk
  import ovs_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic align,
  input  logic run,
  input  logic line,
  output logic bit_done,
  output logic bit_val
);

  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] IDX_S0  = CW'(MID - 1);
  localparam logic [CW-1:0] IDX_S1  = CW'(MID);
  localparam logic [CW-1:0] IDX_S2  = CW'(MID + 1);
  localparam logic [CW-1:0] IDX_TOP = CW'(OVS - 1);

  // index of the next tick to be handled within the current bit
  logic [CW-1:0] idx_q;
  logic          s0_q, s1_q;
  logic          step;

  assign step = run & tick_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (align) begin
      idx_q <= CW'(1);
    end else if (step) begin
      idx_q <= (idx_q == IDX_TOP) ? '0 : idx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else if (step) begin
      if (idx_q == IDX_S0) s0_q <= line;
      if (idx_q == IDX_S1) s1_q <= line;
    end
  end

  assign bit_done = step & (idx_q == IDX_S2);
  assign bit_val  = maj3(s0_q, s1_q, line);

  // R4: timing frozen between ticks
  a_r4_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !align) |=> $stable(idx_q));

endmodule

// File: rtl/ovs_rx_ctrl.sv
module ovs_rx_ctrl
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              line,
  input  logic              fall_tick,
  input  logic              bit_done,
  input  logic              bit_val,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              align,
  output logic              run,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);

  localparam int LEN_MIN = DATA_W - 3;
  localparam int IW      = $clog2(DATA_W);

  rx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     bit_idx;
  logic [IW-1:0]     last_idx_q;
  logic [IW-1:0]     shamt_q;
  logic [1:0]        len_code_q;
  logic              par_en_q, par_odd_q, two_stop_q;
  logic              par_rx_q, stop_idx_q, frm_acc_q;

  // named events
  logic false_start, last_data, last_stop, char_frm;
  logic [DATA_W-1:0] just_data;

  function automatic logic [DATA_W-1:0] justify(input logic [DATA_W-1:0] v,
                                                input logic [IW-1:0] sh);
    return v >> sh;
  endfunction

  function automatic logic parity_of(input logic [DATA_W-1:0] v, input logic odd);
    return (^v) ^ odd;
  endfunction

  assign align       = (state == ST_IDLE) & fall_tick;
  assign run         = (state == ST_START) | (state == ST_DATA) |
                       (state == ST_PAR)   | (state == ST_STOP);
  assign false_start = (state == ST_START) & bit_done & bit_val;
  assign last_data   = (state == ST_DATA) & bit_done & (bit_idx == last_idx_q);
  assign last_stop   = (state == ST_STOP) & bit_done & (stop_idx_q == two_stop_q);
  assign char_frm    = frm_acc_q | ~bit_val;
  assign just_data   = justify(shreg, shamt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bit_idx    <= '0;
      last_idx_q <= '0;
      shamt_q    <= '0;
      len_code_q <= '0;
      par_en_q   <= 1'b0;
      par_odd_q  <= 1'b0;
      two_stop_q <= 1'b0;
      par_rx_q   <= 1'b0;
      stop_idx_q <= 1'b0;
      frm_acc_q  <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall_tick) begin
            state      <= ST_START;
            len_code_q <= cfg_len;
            last_idx_q <= IW'(LEN_MIN - 1) + IW'(cfg_len);
            shamt_q    <= IW'(DATA_W - LEN_MIN) - IW'(cfg_len);
            par_en_q   <= cfg_par_en;
            par_odd_q  <= cfg_par_odd;
            two_stop_q <= cfg_two_stop;
          end
        end
        ST_START: begin
          if (bit_done) begin
            if (bit_val) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_DATA;
              bit_idx <= '0;
              shreg   <= '0;
            end
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            shreg   <= {bit_val, shreg[DATA_W-1:1]};
            bit_idx <= bit_idx + IW'(1);
            if (last_data) begin
              state      <= par_en_q ? ST_PAR : ST_STOP;
              stop_idx_q <= 1'b0;
              frm_acc_q  <= 1'b0;
              par_rx_q   <= 1'b0;
            end
          end
        end
        ST_PAR: begin
          if (bit_done) begin
            par_rx_q <= bit_val;
            state    <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (bit_done) begin
            frm_acc_q <= char_frm;
            if (last_stop) begin
              rx_valid   <= 1'b1;
              rx_data    <= just_data;
              rx_par_err <= par_en_q & (par_rx_q != parity_of(just_data, par_odd_q));
              rx_frm_err <= char_frm;
              state      <= char_frm ? ST_WAIT : ST_IDLE;
            end else begin
              stop_idx_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tick_en && line) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a start edge seen while idle opens a character
  a_r1_edge_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && fall_tick) |=> (state == ST_START));

  // R2: a start bit voted high is dropped without output
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (state == ST_IDLE && !rx_valid));

  // R5: bits above the character length read zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> (LEN_MIN + int'(len_code_q))) == '0));

  // R6: no parity error without a parity bit
  a_r6_par_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en_q) |-> !rx_par_err);

  // R7: framing error leaves the receiver waiting for a high line
  a_r7_frm_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_frm_err) |-> (state == ST_WAIT));

  // R8: valid is a single-cycle pulse
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8: output word held between pulses
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

endmodule

// File: rtl/ovs_async_rx.sv
module ovs_async_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              rxd_in,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);

  logic line, fall_tick, align, run, bit_done, bit_val;

  ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .din       (rxd_in),
    .line      (line),
    .fall_tick (fall_tick)
  );

  ovs_rx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .align    (align),
    .run      (run),
    .line     (line),
    .bit_done (bit_done),
    .bit_val  (bit_val)
  );

  ovs_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .line         (line),
    .fall_tick    (fall_tick),
    .bit_done     (bit_done),
    .bit_val      (bit_val),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_two_stop (cfg_two_stop),
    .align        (align),
    .run          (run),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_par_err   (rx_par_err),
    .rx_frm_err   (rx_frm_err)
  );

  // R9: nothing delivered while the line has stayed idle since reset
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run) && !rx_valid) |=> !rx_valid);

endmodule

// File: tb/ovs_async_rx_test.sv
module ovs_async_rx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       rxd_in = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err;

  int vectors = 0;
  int fails = 0;
  int cap_cnt = 0;
  logic [7:0] cap_data = '0;
  logic cap_pe = 1'b0, cap_fe = 1'b0;
  int tick_gap = 1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ovs_async_rx uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rxd_in(rxd_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_cnt  <= cap_cnt + 1;
      cap_data <= rx_data;
      cap_pe   <= rx_par_err;
      cap_fe   <= rx_frm_err;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  // one oversample tick with line level v; extra idle cycles when tick_gap > 1
  task automatic tick_once(input logic v);
    @(negedge clk);
    rxd_in  = v;
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    for (int g = 1; g < tick_gap; g++) @(negedge clk);
  endtask

  task automatic idle_ticks(input int n, input logic v);
    for (int i = 0; i < n; i++) tick_once(v);
  endtask

  // pm: 0 none, 1 even, 2 odd; bad_stop: index of a stop bit driven 0, -1 none
  task automatic send_char(input logic [7:0] d, input int n, input int pm, input int ns,
                           input int period, input int flip_bit, input int flip_tick,
                           input bit bad_par, input int bad_stop);
    logic [11:0] fr;
    logic [7:0]  dm;
    int          idx;
    logic        p;
    dm = d & 8'((1 << n) - 1);
    cfg_len      = 2'(n - 5);
    cfg_par_en   = (pm != 0);
    cfg_par_odd  = (pm == 2);
    cfg_two_stop = (ns == 2);
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < n; i++) fr[1+i] = dm[i];
    idx = 1 + n;
    if (pm != 0) begin
      p = (^dm) ^ (pm == 2);
      fr[idx] = bad_par ? ~p : p;
      idx++;
    end
    for (int s = 0; s < ns; s++) fr[idx+s] = (s == bad_stop) ? 1'b0 : 1'b1;
    idx = idx + ns;
    for (int b = 0; b < idx; b++) begin
      for (int t = 0; t < period; t++) begin
        tick_once((b == flip_bit && t == flip_tick) ? ~fr[b] : fr[b]);
      end
    end
  endtask

  task automatic expect_char(input string req, input int base, input logic [7:0] ed,
                             input logic epe, input logic efe);
    vectors++;
    if (cap_cnt != base + 1 || cap_data !== ed || cap_pe !== epe || cap_fe !== efe) begin
      fails++;
      $display("FAIL %s: actual count=%0d data=%h pe=%b fe=%b expected count=%0d data=%h pe=%b fe=%b",
               req, cap_cnt - base, cap_data, cap_pe, cap_fe, 1, ed, epe, efe);
    end
  endtask

  task automatic expect_none(input string req, input int base);
    vectors++;
    if (cap_cnt != base) begin
      fails++;
      $display("FAIL %s: actual characters=%0d expected=0", req, cap_cnt - base);
    end
  endtask

  initial begin
    int base;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R9: reset state
    vectors++;
    if (rx_valid !== 1'b0 || rx_data !== 8'h00 || rx_par_err !== 1'b0 || rx_frm_err !== 1'b0) begin
      fails++;
      $display("FAIL R9: actual v=%b d=%h pe=%b fe=%b expected all zero",
               rx_valid, rx_data, rx_par_err, rx_frm_err);
    end
    rst_n = 1'b1;
    idle_ticks(4, 1'b1);

    // R5 R6 R7 R8: sweep of every format with several words
    for (int n = 5; n <= 8; n++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int ns = 1; ns <= 2; ns++) begin
          for (int k = 0; k < 8; k++) begin
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 37 + n * 11 + 13);
            base = cap_cnt;
            send_char(d, n, pm, ns, 16, -1, 0, 1'b0, -1);
            idle_ticks(2, 1'b1);
            expect_char("R5", base, d & 8'((1 << n) - 1), 1'b0, 1'b0);
          end
        end
      end
    end

    // R6: all 5-bit codes with odd parity
    for (int v = 0; v < 32; v++) begin
      base = cap_cnt;
      send_char(8'(v), 5, 2, 1, 16, -1, 0, 1'b0, -1);
      idle_ticks(1, 1'b1);
      expect_char("R6", base, 8'(v), 1'b0, 1'b0);
    end

    // R6: wrong parity bit, even and odd
    base = cap_cnt;
    send_char(8'hA5, 8, 1, 1, 16, -1, 0, 1'b1, -1);
    idle_ticks(2, 1'b1);
    expect_char("R6", base, 8'hA5, 1'b1, 1'b0);
    base = cap_cnt;
    send_char(8'h13, 6, 2, 2, 16, -1, 0, 1'b1, -1);
    idle_ticks(2, 1'b1);
    expect_char("R6", base, 8'h13, 1'b1, 1'b0);

    // R3: single-tick disturbance on each vote sample of a data bit
    for (int t = 7; t <= 9; t++) begin
      base = cap_cnt;
      send_char(8'h5A, 8, 1, 1, 16, 3, t, 1'b0, -1);
      idle_ticks(2, 1'b1);
      expect_char("R3", base, 8'h5A, 1'b0, 1'b0);
    end
    // R3: disturbance on the start bit vote and on the parity bit
    base = cap_cnt;
    send_char(8'h3C, 7, 2, 1, 16, 0, 8, 1'b0, -1);
    idle_ticks(2, 1'b1);
    expect_char("R3", base, 8'h3C, 1'b0, 1'b0);
    base = cap_cnt;
    send_char(8'h3C, 7, 2, 1, 16, 8, 9, 1'b0, -1);
    idle_ticks(2, 1'b1);
    expect_char("R3", base, 8'h3C, 1'b0, 1'b0);

    // R2: start low through tick 7 only, then high -> discarded
    base = cap_cnt;
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    idle_ticks(8, 1'b0);
    idle_ticks(200, 1'b1);
    expect_none("R2", base);
    // R2: short glitch
    idle_ticks(3, 1'b0);
    idle_ticks(200, 1'b1);
    expect_none("R2", base);
    // R1: receiver recovered and takes the next edge
    send_char(8'hC3, 8, 0, 1, 16, -1, 0, 1'b0, -1);
    idle_ticks(2, 1'b1);
    expect_char("R1", base, 8'hC3, 1'b0, 1'b0);

    // R7: stop bit low, line held low, then released
    base = cap_cnt;
    send_char(8'h15, 5, 0, 1, 16, -1, 0, 1'b0, 0);
    idle_ticks(40, 1'b0);
    expect_char("R7", base, 8'h15, 1'b0, 1'b1);
    idle_ticks(5, 1'b1);
    base = cap_cnt;
    send_char(8'h0A, 5, 0, 1, 16, -1, 0, 1'b0, -1);
    idle_ticks(2, 1'b1);
    expect_char("R7", base, 8'h0A, 1'b0, 1'b0);
    // R7: second of two stop bits low
    base = cap_cnt;
    send_char(8'h66, 8, 1, 2, 16, -1, 0, 1'b0, 1);
    idle_ticks(4, 1'b1);
    expect_char("R7", base, 8'h66, 1'b0, 1'b1);

    // R4: slow and fast bit periods back to back
    base = cap_cnt;
    send_char(8'h19, 5, 0, 1, 17, -1, 0, 1'b0, -1);
    expect_char("R4", base, 8'h19, 1'b0, 1'b0);
    base = cap_cnt;
    send_char(8'h06, 5, 0, 1, 15, -1, 0, 1'b0, -1);
    idle_ticks(3, 1'b1);
    expect_char("R4", base, 8'h06, 1'b0, 1'b0);
    base = cap_cnt;
    send_char(8'h1E, 5, 0, 1, 16, -1, 0, 1'b0, -1);
    idle_ticks(2, 1'b1);
    expect_char("R4", base, 8'h1E, 1'b0, 1'b0);

    // R4: ticks spaced by idle cycles
    tick_gap = 4;
    base = cap_cnt;
    send_char(8'h9B, 8, 2, 2, 16, -1, 0, 1'b0, -1);
    idle_ticks(2, 1'b1);
    expect_char("R4", base, 8'h9B, 1'b0, 1'b0);
    tick_gap = 1;

    // R8: exactly one pulse and value held afterwards
    idle_ticks(30, 1'b1);
    vectors++;
    if (rx_data !== 8'h9B || rx_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8: actual data=%h v=%b expected data=9b v=0", rx_data, rx_valid);
    end

    finish_run();
  end

endmodule